// File: doc/BRIEF.md
# Functional Unit Token Stage

This block is the token-level shadow of one functional unit in a coarse-grained array. It sits one cycle ahead of the arithmetic datapath. A token is a one-bit notice that an operand will arrive next cycle on a given input position. From the set of positions that carry tokens, the block works out the operand multiplexer selects. It also requests the operation's configuration only when there is work to do. It turns the fetched opcode into a latency and an output token kind. When the result is due, it emits tokens towards at most two consumers.

Each token carries a staging bit that marks whether its loop iteration is live. The block combines the staging bits of the tokens that trigger an operation. Guarded operations are suppressed when the combined bit is false. Configuration memory is outside the block and returns the requested fields one cycle after the request. The arithmetic itself is also outside the block.

Top module: `fu_token_unit`

## Requirements
- R1: `cfg_req` is high in the cycle in which any bit of `tok_in` is high, and low in every cycle in which `tok_in` is all zero, so no configuration fetch happens on idle cycles.
- R2: One cycle after tokens arrive, `op_sel_vld` is high. `op_sel_a` holds the lowest token position and `op_sel_b` the next higher one. With a single token, both selects equal that position.
- R3: The class is `cfg_opc[3:2]`. The classes are: 00 = one-operand move (latency 1); 01 = two-operand ALU (latency 1); 10 = two-operand multiply (latency 3); 11 = two-operand compare (latency 2). For tokens in cycle t, the output token is present only in cycle t+1+latency.
- R4: Classes 00, 01 and 10 emit on `tok_data_en`, and class 11 emits on `tok_pred_en`. The other line stays low.
- R5: An output token carries the fetched `cfg_dst0`/`cfg_dst1` on `tok_dst0`/`tok_dst1`. Bit k of the enable pair is set only when bit k of `cfg_dst_en` is set, so at most two consumers are addressed.
- R6: `tok_stg` is the AND of the staging bits of the positions that carried tokens; staging bits of positions without a token are ignored. When `cfg_guard` is high and that AND is false, no output token is sent. When `cfg_guard` is low, the token is sent regardless.
- R7: A one-operand class with other than one token, or a two-operand class with other than two tokens, raises `err_arity` for the single cycle t+2, and no output token is sent for that operation.
- R8: After reset, all outputs other than `cfg_req` are zero.
- R9: Operations may start in consecutive cycles. Each completes at its own latency, so a short operation may finish before an earlier long one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_in | input | NUM_IN | Incoming token per operand position |
| stg_in | input | NUM_IN | Staging bit per operand position |
| cfg_req | output | 1 | Request to read this unit's configuration |
| cfg_opc | input | OPC_W | Fetched opcode, valid the cycle after a request |
| cfg_guard | input | 1 | Fetched flag: operation is guarded by the staging bit |
| cfg_dst0 | input | DST_W | Fetched first destination |
| cfg_dst1 | input | DST_W | Fetched second destination |
| cfg_dst_en | input | 2 | Fetched destination enables |
| op_sel_vld | output | 1 | Operand selects valid (execute cycle) |
| op_sel_a | output | SEL_W | First operand select |
| op_sel_b | output | SEL_W | Second operand select |
| tok_dst0 | output | DST_W | Destination of output slot 0 |
| tok_dst1 | output | DST_W | Destination of output slot 1 |
| tok_data_en | output | 2 | Data token per destination slot |
| tok_pred_en | output | 2 | Predicate token per destination slot |
| tok_stg | output | 1 | Staging bit travelling with the output token |
| err_arity | output | 1 | Token count did not match the opcode's operand count |

## Verification
The assertions take for granted that the configuration fields returned after a request belong to that request. They also assume the schedule never lets two operations complete in the same cycle: a launch must not land on a completion slot that is still occupied. The stimulus keeps to this by presenting each operation's fields when its tokens are driven. Where operations overlap, it orders them so that their completion cycles differ, as in the long-then-short pair.

// File: rtl/fu_tok_pkg.sv
package fu_tok_pkg;

  localparam int MAX_LAT = 3;
  localparam int LAT_W   = $clog2(MAX_LAT + 1);

  typedef enum logic [1:0] {
    CLS_MOVE = 2'b00,
    CLS_ALU  = 2'b01,
    CLS_MUL  = 2'b10,
    CLS_CMP  = 2'b11
  } op_cls_e;

  typedef struct packed {
    logic [LAT_W-1:0] lat;
    logic             pred;
    logic             binary;
  } op_attr_t;

  function automatic op_attr_t decode_cls(op_cls_e c);
    op_attr_t a;
    case (c)
      CLS_MOVE: a = '{lat: LAT_W'(1), pred: 1'b0, binary: 1'b0};
      CLS_ALU:  a = '{lat: LAT_W'(1), pred: 1'b0, binary: 1'b1};
      CLS_MUL:  a = '{lat: LAT_W'(3), pred: 1'b0, binary: 1'b1};
      default:  a = '{lat: LAT_W'(2), pred: 1'b1, binary: 1'b1};
    endcase
    return a;
  endfunction

endpackage

// File: rtl/fu_tok_rx.sv
module fu_tok_rx #(
  parameter int NUM_IN = 4,
  parameter int SEL_W  = $clog2(NUM_IN),
  parameter int CNT_W  = $clog2(NUM_IN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] tok_in,
  input  logic [NUM_IN-1:0] stg_in,
  output logic              cfg_req,
  output logic              sel_vld,
  output logic [SEL_W-1:0]  sel_a,
  output logic [SEL_W-1:0]  sel_b,
  output logic [CNT_W-1:0]  tok_cnt,
  output logic              stg_all
);

  logic [SEL_W-1:0] a_n, b_n;
  logic [CNT_W-1:0] cnt_n;
  logic             stg_n, got_a, got_b;

  assign cfg_req = |tok_in;

  always_comb begin
    a_n   = '0;
    b_n   = '0;
    cnt_n = '0;
    stg_n = 1'b1;
    got_a = 1'b0;
    got_b = 1'b0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (tok_in[i]) begin
        cnt_n = cnt_n + CNT_W'(1);
        stg_n = stg_n & stg_in[i];
        if (!got_a) begin
          a_n   = SEL_W'(i);
          got_a = 1'b1;
        end else if (!got_b) begin
          b_n   = SEL_W'(i);
          got_b = 1'b1;
        end
      end
    end
    if (!got_b) b_n = a_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_vld <= 1'b0;
      sel_a   <= '0;
      sel_b   <= '0;
      tok_cnt <= '0;
      stg_all <= 1'b0;
    end else begin
      sel_vld <= cfg_req;
      sel_a   <= a_n;
      sel_b   <= b_n;
      tok_cnt <= cnt_n;
      stg_all <= stg_n;
    end
  end

  // R2: a token cycle is always followed by an execute cycle
  a_r2_vld_after_req: assert property (@(posedge clk) disable iff (rst)
    cfg_req |=> sel_vld);

  // R2: first select never lies above the second
  a_r2_sel_order: assert property (@(posedge clk) disable iff (rst)
    sel_vld |-> (sel_a <= sel_b));

endmodule

// File: rtl/fu_tok_opproc.sv
module fu_tok_opproc
  import fu_tok_pkg::*;
#(
  parameter int OPC_W = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pend,
  input  logic [CNT_W-1:0] tok_cnt,
  input  logic             stg_all,
  input  logic [OPC_W-1:0] cfg_opc,
  input  logic             cfg_guard,
  output logic             launch,
  output logic [LAT_W-1:0] lat,
  output logic             pred,
  output logic             err_arity
);

  op_attr_t attr;
  logic     count_ok;

  assign attr     = decode_cls(op_cls_e'(cfg_opc[OPC_W-1 -: 2]));
  assign lat      = attr.lat;
  assign pred     = attr.pred;
  assign count_ok = (tok_cnt == CNT_W'(attr.binary ? 2 : 1));
  assign launch   = pend && count_ok && (!cfg_guard || stg_all);

  always_ff @(posedge clk) begin
    if (rst) err_arity <= 1'b0;
    else     err_arity <= pend && !count_ok;
  end

  // R3: every launched operation has a latency the completion slots can hold
  a_r3_lat_range: assert property (@(posedge clk) disable iff (rst)
    launch |-> (lat >= LAT_W'(1) && lat <= LAT_W'(MAX_LAT)));

endmodule

// File: rtl/fu_tok_tx.sv
module fu_tok_tx
  import fu_tok_pkg::*;
#(
  parameter int DST_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic [LAT_W-1:0] lat,
  input  logic             pred,
  input  logic             stg,
  input  logic [DST_W-1:0] dst0,
  input  logic [DST_W-1:0] dst1,
  input  logic [1:0]       dst_en,
  output logic [DST_W-1:0] tok_dst0,
  output logic [DST_W-1:0] tok_dst1,
  output logic [1:0]       tok_data_en,
  output logic [1:0]       tok_pred_en,
  output logic             tok_stg
);

  logic [MAX_LAT-1:0] s_vld, s_pred, s_stg;
  logic [DST_W-1:0]   s_d0 [MAX_LAT];
  logic [DST_W-1:0]   s_d1 [MAX_LAT];
  logic [1:0]         s_en [MAX_LAT];
  logic [MAX_LAT:0]   occ_next;
  logic               clash;

  for (genvar g = 0; g < MAX_LAT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        s_vld[g]  <= 1'b0;
        s_pred[g] <= 1'b0;
        s_stg[g]  <= 1'b0;
        s_d0[g]   <= '0;
        s_d1[g]   <= '0;
        s_en[g]   <= '0;
      end else if (launch && int'(lat) == g + 1) begin
        s_vld[g]  <= 1'b1;
        s_pred[g] <= pred;
        s_stg[g]  <= stg;
        s_d0[g]   <= dst0;
        s_d1[g]   <= dst1;
        s_en[g]   <= dst_en;
      end else begin
        if (g == MAX_LAT - 1) begin : g_tail
          s_vld[g] <= 1'b0;
        end else begin : g_shift
          s_vld[g]  <= s_vld[g+1];
          s_pred[g] <= s_pred[g+1];
          s_stg[g]  <= s_stg[g+1];
          s_d0[g]   <= s_d0[g+1];
          s_d1[g]   <= s_d1[g+1];
          s_en[g]   <= s_en[g+1];
        end
      end
    end
  end

  assign tok_dst0    = s_d0[0];
  assign tok_dst1    = s_d1[0];
  assign tok_stg     = s_vld[0] & s_stg[0];
  assign tok_data_en = (s_vld[0] && !s_pred[0]) ? s_en[0] : 2'b00;
  assign tok_pred_en = (s_vld[0] &&  s_pred[0]) ? s_en[0] : 2'b00;

  // slot that would shift into the insertion point this edge
  assign occ_next = {1'b0, s_vld};
  assign clash    = occ_next[lat];

  // R3: schedule never makes two operations finish in one cycle
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
    launch |-> !clash);

  // R4: one output token is either data or predicate, never both
  a_r4_line_excl: assert property (@(posedge clk) disable iff (rst)
    !((|tok_data_en) && (|tok_pred_en)));

endmodule

// File: rtl/fu_token_unit.sv
module fu_token_unit
  import fu_tok_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int OPC_W  = 4,
  parameter int DST_W  = 3,
  localparam int SEL_W = $clog2(NUM_IN),
  localparam int CNT_W = $clog2(NUM_IN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] tok_in,
  input  logic [NUM_IN-1:0] stg_in,
  output logic              cfg_req,
  input  logic [OPC_W-1:0]  cfg_opc,
  input  logic              cfg_guard,
  input  logic [DST_W-1:0]  cfg_dst0,
  input  logic [DST_W-1:0]  cfg_dst1,
  input  logic [1:0]        cfg_dst_en,
  output logic              op_sel_vld,
  output logic [SEL_W-1:0]  op_sel_a,
  output logic [SEL_W-1:0]  op_sel_b,
  output logic [DST_W-1:0]  tok_dst0,
  output logic [DST_W-1:0]  tok_dst1,
  output logic [1:0]        tok_data_en,
  output logic [1:0]        tok_pred_en,
  output logic              tok_stg,
  output logic              err_arity
);

  logic [CNT_W-1:0] tok_cnt;
  logic             stg_all, launch, pred;
  logic [LAT_W-1:0] lat;

  fu_tok_rx #(.NUM_IN(NUM_IN), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .tok_in(tok_in), .stg_in(stg_in),
    .cfg_req(cfg_req), .sel_vld(op_sel_vld), .sel_a(op_sel_a),
    .sel_b(op_sel_b), .tok_cnt(tok_cnt), .stg_all(stg_all)
  );

  fu_tok_opproc #(.OPC_W(OPC_W), .CNT_W(CNT_W)) u_op (
    .clk(clk), .rst(rst), .pend(op_sel_vld), .tok_cnt(tok_cnt),
    .stg_all(stg_all), .cfg_opc(cfg_opc), .cfg_guard(cfg_guard),
    .launch(launch), .lat(lat), .pred(pred), .err_arity(err_arity)
  );

  fu_tok_tx #(.DST_W(DST_W)) u_tx (
    .clk(clk), .rst(rst), .launch(launch), .lat(lat), .pred(pred),
    .stg(stg_all), .dst0(cfg_dst0), .dst1(cfg_dst1), .dst_en(cfg_dst_en),
    .tok_dst0(tok_dst0), .tok_dst1(tok_dst1), .tok_data_en(tok_data_en),
    .tok_pred_en(tok_pred_en), .tok_stg(tok_stg)
  );

  // R7: an arity error only follows an execute cycle
  a_r7_err_after_exec: assert property (@(posedge clk) disable iff (rst)
    err_arity |-> $past(op_sel_vld));

endmodule

// File: tb/sim_fu_token_unit.sv
module sim_fu_token_unit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] tok_in = '0, stg_in = '1;
  logic       cfg_req;
  logic [3:0] cfg_opc = '0;
  logic       cfg_guard = 1'b0;
  logic [2:0] cfg_dst0 = '0, cfg_dst1 = '0;
  logic [1:0] cfg_dst_en = '0;
  logic       op_sel_vld;
  logic [1:0] op_sel_a, op_sel_b;
  logic [2:0] tok_dst0, tok_dst1;
  logic [1:0] tok_data_en, tok_pred_en;
  logic       tok_stg, err_arity;

  logic [3:0] nx_opc = '0;
  logic       nx_guard = 1'b0;
  logic [2:0] nx_d0 = '0, nx_d1 = '0;
  logic [1:0] nx_en = '0;
  int         fetches = 0;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  fu_token_unit u0 (
    .clk(clk), .rst(rst), .tok_in(tok_in), .stg_in(stg_in),
    .cfg_req(cfg_req), .cfg_opc(cfg_opc), .cfg_guard(cfg_guard),
    .cfg_dst0(cfg_dst0), .cfg_dst1(cfg_dst1), .cfg_dst_en(cfg_dst_en),
    .op_sel_vld(op_sel_vld), .op_sel_a(op_sel_a), .op_sel_b(op_sel_b),
    .tok_dst0(tok_dst0), .tok_dst1(tok_dst1), .tok_data_en(tok_data_en),
    .tok_pred_en(tok_pred_en), .tok_stg(tok_stg), .err_arity(err_arity)
  );

  // configuration memory model: synchronous read on request
  always @(posedge clk) begin
    if (cfg_req) begin
      cfg_opc    <= nx_opc;
      cfg_guard  <= nx_guard;
      cfg_dst0   <= nx_d0;
      cfg_dst1   <= nx_d1;
      cfg_dst_en <= nx_en;
      fetches    <= fetches + 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // drive tokens for one cycle; returns sampled in the execute cycle
  task automatic issue(input logic [3:0] tok, input logic [3:0] stg,
                       input logic [3:0] opc, input logic guard,
                       input logic [2:0] d0, input logic [2:0] d1,
                       input logic [1:0] en);
    @(negedge clk);
    tok_in = tok; stg_in = stg;
    nx_opc = opc; nx_guard = guard; nx_d0 = d0; nx_d1 = d1; nx_en = en;
    #1;
    check("R1 req on tokens", int'(cfg_req), 1);
    @(negedge clk);
    tok_in = '0; stg_in = '1;
    #1;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    step(1);
    check("R8 sel_vld", int'(op_sel_vld), 0);
    check("R8 data_en", int'(tok_data_en), 0);
    check("R8 pred_en", int'(tok_pred_en), 0);
    check("R8 err", int'(err_arity), 0);
    check("R8 sel", int'({op_sel_a, op_sel_b}), 0);
  endtask

  task automatic t_idle;
    int f0;
    f0 = fetches;
    for (int i = 0; i < 5; i++) begin
      step(1);
      check("R1 no req idle", int'(cfg_req), 0);
      check("R2 no vld idle", int'(op_sel_vld), 0);
    end
    check("R1 no fetch idle", fetches, f0);
  endtask

  task automatic t_alu;
    issue(4'b0110, 4'b1111, 4'b0100, 1'b0, 3'd5, 3'd2, 2'b11);
    check("R2 vld", int'(op_sel_vld), 1);
    check("R2 sel_a", int'(op_sel_a), 1);
    check("R2 sel_b", int'(op_sel_b), 2);
    step(1);
    check("R3 alu lat1", int'(tok_data_en), 3);
    check("R4 alu no pred", int'(tok_pred_en), 0);
    check("R5 dst0", int'(tok_dst0), 5);
    check("R5 dst1", int'(tok_dst1), 2);
    check("R6 stg", int'(tok_stg), 1);
    step(1);
    check("R3 alu pulse", int'(tok_data_en), 0);
  endtask

  task automatic t_mul;
    issue(4'b1001, 4'b1111, 4'b1000, 1'b0, 3'd7, 3'd0, 2'b01);
    check("R2 sel_a mul", int'(op_sel_a), 0);
    check("R2 sel_b mul", int'(op_sel_b), 3);
    step(1);
    check("R3 mul t+2", int'(tok_data_en), 0);
    step(1);
    check("R3 mul t+3", int'(tok_data_en), 0);
    step(1);
    check("R3 mul t+4", int'(tok_data_en), 1);
    check("R5 mul dst0", int'(tok_dst0), 7);
    step(1);
    check("R3 mul pulse", int'(tok_data_en), 0);
  endtask

  task automatic t_cmp;
    issue(4'b1100, 4'b1111, 4'b1100, 1'b0, 3'd1, 3'd6, 2'b10);
    step(1);
    check("R3 cmp t+2", int'(tok_pred_en), 0);
    step(1);
    check("R4 cmp pred", int'(tok_pred_en), 2);
    check("R4 cmp no data", int'(tok_data_en), 0);
    check("R5 cmp dst1", int'(tok_dst1), 6);
    step(1);
    check("R3 cmp pulse", int'(tok_pred_en), 0);
  endtask

  task automatic t_unary;
    issue(4'b0100, 4'b1111, 4'b0011, 1'b0, 3'd3, 3'd0, 2'b01);
    check("R2 unary sel_a", int'(op_sel_a), 2);
    check("R2 unary sel_b", int'(op_sel_b), 2);
    step(1);
    check("R3 move lat1", int'(tok_data_en), 1);
    check("R7 no err", int'(err_arity), 0);
  endtask

  task automatic t_arity;
    issue(4'b0001, 4'b1111, 4'b0100, 1'b0, 3'd2, 3'd0, 2'b11);
    step(1);
    check("R7 err bin", int'(err_arity), 1);
    check("R7 no tok", int'(tok_data_en), 0);
    step(1);
    check("R7 err pulse", int'(err_arity), 0);
    check("R7 no tok late", int'(tok_data_en | tok_pred_en), 0);
    issue(4'b0011, 4'b1111, 4'b0000, 1'b0, 3'd2, 3'd0, 2'b11);
    step(1);
    check("R7 err unary", int'(err_arity), 1);
    check("R7 no tok unary", int'(tok_data_en), 0);
    step(2);
    check("R7 quiet", int'(tok_data_en | tok_pred_en | {1'b0, err_arity}), 0);
  endtask

  task automatic t_stage;
    // guarded, one token staging bit false -> suppressed
    issue(4'b0110, 4'b1011, 4'b0100, 1'b1, 3'd4, 3'd0, 2'b01);
    step(1);
    check("R6 guarded drop", int'(tok_data_en), 0);
    // unguarded, same staging -> sent with staging low
    issue(4'b0110, 4'b1011, 4'b0100, 1'b0, 3'd4, 3'd0, 2'b01);
    step(1);
    check("R6 unguarded sent", int'(tok_data_en), 1);
    check("R6 unguarded stg", int'(tok_stg), 0);
    // guarded, zeros only on untokened positions -> sent, staging high
    issue(4'b0110, 4'b0110, 4'b0100, 1'b1, 3'd4, 3'd0, 2'b01);
    step(1);
    check("R6 ignore idle pos", int'(tok_data_en), 1);
    check("R6 stg high", int'(tok_stg), 1);
  endtask

  task automatic t_b2b;
    @(negedge clk);
    tok_in = 4'b0011; nx_opc = 4'b1000; nx_guard = 1'b0;
    nx_d0 = 3'd1; nx_d1 = 3'd0; nx_en = 2'b01;
    #1;
    check("R1 req A", int'(cfg_req), 1);
    @(negedge clk);
    tok_in = 4'b1100; nx_opc = 4'b0100; nx_d0 = 3'd4; nx_en = 2'b01;
    #1;
    check("R9 sel_a A", int'(op_sel_a), 0);
    check("R9 sel_b A", int'(op_sel_b), 1);
    @(negedge clk);
    tok_in = '0;
    #1;
    check("R9 sel_a B", int'(op_sel_a), 2);
    check("R9 sel_b B", int'(op_sel_b), 3);
    step(1);
    check("R9 B first", int'(tok_data_en), 1);
    check("R9 B dst", int'(tok_dst0), 4);
    step(1);
    check("R9 A second", int'(tok_data_en), 1);
    check("R9 A dst", int'(tok_dst0), 1);
    step(1);
    check("R9 drained", int'(tok_data_en), 0);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_alu();
    t_mul();
    t_cmp();
    t_unary();
    t_arity();
    t_stage();
    t_b2b();
    step(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule